// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This block makes the three conditional decisions a descriptor-driven DMA sequencer needs when a descriptor completes. It decides whether the channel must stall, whether to take the branch target rather than advance in sequence, and whether to raise an interrupt. Each decision combines a 2-bit mode field taken from the descriptor's command word with a mask-and-compare test of the channel's 4-bit device status. Each decision has its own select register holding the mask and the compare value.

The sequencer offers an evaluation on a valid/ready request channel, carrying the three mode fields and the current device status. The block answers one cycle later on a valid/ready result channel with a branch flag and a wait flag. A result waits in its register until the sequencer takes it. While that result is held, the request side reports not-ready, so back-pressure from the result side reaches the request side directly. The interrupt is a level output. It is set by an evaluation that decides to interrupt and stays set until the host pulses the clear input. The three select registers are written and read back through a plain register port.

Top module: `cond_eval_unit`

## Requirements
- R1: After reset all three select registers read zero, `res_valid` and `irq` are low, and `req_ready` is high.
- R2: Select register code 0 is interrupt, 1 is branch and 2 is wait. A write keeps data bits 19:16 as the mask and bits 3:0 as the compare value. Every other bit reads back zero. A write with code 3 changes no register, and code 3 reads zero.
- R3: A decision's condition is true when (status AND mask) equals (compare value AND mask), so a zero mask always yields true.
- R4: Every mode field uses the same encoding: 0 never, 1 if condition true, 2 if condition false, 3 always.
- R5: `res_wait` is set when the wait mode decides to stall. Mode 3 always stalls and mode 0 never stalls.
- R6: When the wait decision stalls, the evaluation raises no interrupt and `res_branch` is 0.
- R7: When the channel is not stalled, branch mode 0 gives `res_branch`=0 and mode 3 gives `res_branch`=1, whatever the condition.
- R8: `irq` rises in the cycle after an accepted evaluation that decides to interrupt. It stays high until `irq_clr` is sampled high. When an interrupt-setting acceptance and a clear fall in the same cycle, the set wins.
- R9: A result appears on `res_valid` one cycle after the request is accepted. It holds with its flags unchanged while `res_ready` is low. `req_ready` equals NOT `res_valid` OR `res_ready`.
- R10: A register write in the same cycle as an accepted request does not affect that request's decisions, only later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Select register write strobe |
| reg_sel | input | 2 | Select register code (0 interrupt, 1 branch, 2 wait) |
| reg_wdata | input | 32 | Write data (mask 19:16, compare 3:0) |
| reg_rdata | output | 32 | Read-back of the register chosen by reg_sel |
| req_valid | input | 1 | Evaluation request valid |
| req_ready | output | 1 | Evaluation request can be accepted |
| int_mode | input | 2 | Interrupt mode field |
| br_mode | input | 2 | Branch mode field |
| wait_mode | input | 2 | Wait mode field |
| dev_status | input | 4 | Channel device status bits |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Sequencer takes the result |
| res_branch | output | 1 | Take the branch target |
| res_wait | output | 1 | Stall the channel |
| irq_clr | input | 1 | Host interrupt clear |
| irq | output | 1 | Interrupt level |

## Verification
A corrupted mask or compare bit shows up on the same cycle on `reg_rdata`. It also shows up one cycle after the next accepted request whose status makes that bit matter, as a wrong branch flag, a wrong wait flag or a wrong `irq` level. A lost or duplicated result breaks the in-order pairing of requests and results, and that is seen at the next result handshake. A result register that drifts while back-pressured changes `res_branch` or `res_wait` before `res_ready` returns.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  typedef enum logic [1:0] {
    CM_NEVER    = 2'd0,
    CM_IF_TRUE  = 2'd1,
    CM_IF_FALSE = 2'd2,
    CM_ALWAYS   = 2'd3
  } cmode_e;

  localparam int NUM_SEL   = 3;
  localparam int SEL_INTR  = 0;
  localparam int SEL_BRNCH = 1;
  localparam int SEL_WAIT  = 2;
endpackage

// File: rtl/cond_sel_reg.sv
module cond_sel_reg #(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [STAT_W-1:0] mask_q,
  output logic [STAT_W-1:0] cmp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      mask_q <= wdata[MASK_LSB +: STAT_W];
      cmp_q  <= wdata[STAT_W-1:0];
    end
  end
endmodule

// File: rtl/cond_decide.sv
module cond_decide
  import cond_eval_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic [1:0]        mode,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] cmp,
  output logic              fire
);
  logic cond;

  always_comb begin
    cond = ((status & mask) == (cmp & mask));
    case (cmode_e'(mode))
      CM_NEVER:    fire = 1'b0;
      CM_IF_TRUE:  fire = cond;
      CM_IF_FALSE: fire = !cond;
      default:     fire = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import cond_eval_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        int_mode,
  input  logic [1:0]        br_mode,
  input  logic [1:0]        wait_mode,
  input  logic [STAT_W-1:0] dev_status,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_branch,
  output logic              res_wait,
  input  logic              irq_clr,
  output logic              irq
);
  logic [STAT_W-1:0] mask_a [NUM_SEL];
  logic [STAT_W-1:0] cmp_a  [NUM_SEL];
  logic [1:0]        mode_a [NUM_SEL];
  logic [NUM_SEL-1:0] fire;
  logic accept;

  assign mode_a[SEL_INTR]  = int_mode;
  assign mode_a[SEL_BRNCH] = br_mode;
  assign mode_a[SEL_WAIT]  = wait_mode;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    cond_sel_reg #(
      .DATA_W(DATA_W), .STAT_W(STAT_W), .MASK_LSB(MASK_LSB)
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr && (reg_sel == 2'(g))),
      .wdata (reg_wdata),
      .mask_q(mask_a[g]),
      .cmp_q (cmp_a[g])
    );
    cond_decide #(.STAT_W(STAT_W)) u_dec (
      .mode  (mode_a[g]),
      .status(dev_status),
      .mask  (mask_a[g]),
      .cmp   (cmp_a[g]),
      .fire  (fire[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (reg_sel == 2'(k)) begin
        reg_rdata[MASK_LSB +: STAT_W] = mask_a[k];
        reg_rdata[STAT_W-1:0]         = cmp_a[k];
      end
    end
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_branch <= 1'b0;
      res_wait   <= 1'b0;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_wait   <= fire[SEL_WAIT];
      res_branch <= !fire[SEL_WAIT] && fire[SEL_BRNCH];
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (accept && !fire[SEL_WAIT] && fire[SEL_INTR]) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] br_mode,
  input logic [1:0] wait_mode,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_branch,
  input logic       res_wait,
  input logic       irq_clr,
  input logic       irq
);
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_branch) && $stable(res_wait)); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!res_valid || res_ready)); // R9
  AST_STALL_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wait |-> !res_branch); // R6
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(req_valid && req_ready)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R8
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !(req_valid && req_ready) |=> !irq); // R8
  AST_ALWAYS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && br_mode == 2'd3 && wait_mode == 2'd0 |=> res_branch); // R7
  AST_NEVER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && wait_mode == 2'd0 |=> !res_wait); // R5
  AST_ALWAYS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && wait_mode == 2'd3 |=> res_wait); // R5
endmodule

bind cond_eval_unit cond_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .br_mode(br_mode), .wait_mode(wait_mode), .res_valid(res_valid),
  .res_ready(res_ready), .res_branch(res_branch), .res_wait(res_wait),
  .irq_clr(irq_clr), .irq(irq)
);

// File: tb/sim_cond_eval_unit.sv
module sim_cond_eval_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  int_mode = 2'd0, br_mode = 2'd0, wait_mode = 2'd0;
  logic [3:0]  dev_status = 4'd0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_branch, res_wait;
  logic        irq_clr = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_q[$];
  logic [3:0] sh_mask [3];
  logic [3:0] sh_cmp  [3];
  bit irq_exp = 1'b0;

  always #4 clk = !clk;

  cond_eval_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .int_mode(int_mode), .br_mode(br_mode),
    .wait_mode(wait_mode), .dev_status(dev_status), .res_valid(res_valid),
    .res_ready(res_ready), .res_branch(res_branch), .res_wait(res_wait),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit decide(input logic [1:0] m, input bit c);
    case (m)
      2'd0: return 1'b0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit cond_of(input int k, input logic [3:0] st);
    return (st & sh_mask[k]) == (sh_cmp[k] & sh_mask[k]);
  endfunction

  // scoreboard monitor: sample just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", {30'd0, res_branch, res_wait}, 32'd0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check({res_branch, res_wait} == e, "R5/R6/R7 result flags",
                {30'd0, res_branch, res_wait}, {30'd0, e});
        end
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (s < 2'd3) begin
      sh_mask[s] = d[19:16];
      sh_cmp[s]  = d[3:0];
    end
  endtask

  task automatic readback(input logic [1:0] s);
    logic [31:0] e;
    e = (s < 2'd3) ? {12'd0, sh_mask[s], 12'd0, sh_cmp[s]} : 32'd0;
    reg_sel = s;
    #1;
    check(reg_rdata == e, "R2 readback", reg_rdata, e);
  endtask

  task automatic send(input logic [1:0] im, input logic [1:0] bm, input logic [1:0] wm,
                      input logic [3:0] st, input bit clr);
    bit w, b, i, acc;
    w = decide(wm, cond_of(2, st));
    b = !w && decide(bm, cond_of(1, st));
    i = !w && decide(im, cond_of(0, st));
    exp_q.push_back({b, w});
    @(negedge clk);
    req_valid = 1'b1; int_mode = im; br_mode = bm; wait_mode = wm; dev_status = st;
    irq_clr = clr;
    do begin
      #3 acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0; irq_clr = 1'b0;
    irq_exp = i ? 1'b1 : (clr ? 1'b0 : irq_exp);
    check(irq == irq_exp, "R8 irq after evaluation", {31'd0, irq}, {31'd0, irq_exp});
  endtask

  task automatic clear_irq;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    irq_exp = 1'b0;
    check(irq == 1'b0, "R8 clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin sh_mask[k] = '0; sh_cmp[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(res_valid == 1'b0, "R1 res_valid", {31'd0, res_valid}, 32'd0);
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    check(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
    for (int k = 0; k < 3; k++) readback(2'(k));

    // R3 zero mask: condition true for any status
    send(2'd1, 2'd1, 2'd2, 4'hA, 1'b0);
    send(2'd2, 2'd2, 2'd1, 4'h5, 1'b0);
    clear_irq();

    // R2 field placement and ignored code 3
    wr(2'd0, 32'hFFFF_FFFF);
    readback(2'd0);
    wr(2'd3, 32'h000F_000F);
    readback(2'd3);
    readback(2'd1);
    readback(2'd2);
    wr(2'd0, 32'hA5AC_5A58);
    wr(2'd1, 32'h0003_0001);
    wr(2'd2, 32'h0001_0001);
    for (int k = 0; k < 3; k++) readback(2'(k));

    // R4/R5/R6/R7/R8 all mode combinations over several statuses
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 64; m++) begin
        logic [3:0] st;
        st = (s == 0) ? 4'h0 : (s == 1) ? 4'h5 : (s == 2) ? 4'h9 : 4'hE;
        send(m[5:4], m[3:2], m[1:0], st, 1'b0);
        if (irq_exp) clear_irq();
      end
    end

    // R8 set wins over a simultaneous clear
    send(2'd3, 2'd0, 2'd0, 4'h0, 1'b0);
    send(2'd3, 2'd0, 2'd0, 4'h0, 1'b1);
    check(irq == 1'b1, "R8 set beats clear", {31'd0, irq}, 32'd1);
    clear_irq();
    // R6 stall suppresses interrupt even in always mode
    send(2'd3, 2'd3, 2'd3, 4'h3, 1'b0);
    check(irq == 1'b0, "R6 no irq while stalled", {31'd0, irq}, 32'd0);

    // R9 back-pressure
    @(negedge clk); res_ready = 1'b0;
    send(2'd0, 2'd3, 2'd0, 4'h0, 1'b0);
    fork
      send(2'd0, 2'd0, 2'd3, 4'h0, 1'b0);
    join_none
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(res_valid && res_branch && !res_wait, "R9 held result",
            {29'd0, res_valid, res_branch, res_wait}, 32'd6);
      check(req_ready == 1'b0, "R9 req_ready low", {31'd0, req_ready}, 32'd0);
    end
    @(negedge clk); res_ready = 1'b1;
    wait fork;

    // R10 write coinciding with a request
    fork
      send(2'd0, 2'd1, 2'd0, 4'h1, 1'b0);
      wr(2'd1, 32'h0003_0002);
    join
    send(2'd0, 2'd1, 2'd0, 4'h1, 1'b0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule